// File: doc/BRIEF.md
# Prioritized Interrupt Vector Generator

This block arbitrates among up to 64 interrupt request lines. Each line has a 2-bit priority level, supplied on a packed input. The block picks one winning request and presents a 21-bit vector address to the processor core. The address is built from a 14-bit base value held in a register, placed above the winner's 6-bit request number. The winner's number is shifted left by one because each table entry is two words wide.

Two selector registers can each name one request line as a fast interrupt. When that line is pending at level 2 and nothing is pending at level 3, it takes the top position within level 2. The block then raises a fast flag and a one-bit slot index, so that the core can branch straight to a dedicated service routine instead of going through the table. Slot 0 outranks slot 1.

The three registers sit on a 16-bit register bus with a 2-bit address. The base register is at address 0, slot 0 at address 1, slot 1 at address 2, and address 3 is empty. The vector, the valid flag and the fast indication are registered outputs.

Top module: `irq_vector_gen`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, and `vec_valid`, `vec_fast`, `vec_slot` and `vec_addr` are 0.
- R2: Address 0 holds the vector base in bits 13:0. Bits 15:14 always read 0, and writes to them are dropped.
- R3: Addresses 1 and 2 hold the slot 0 and slot 1 request numbers in bits 5:0. Bits 15:6 read 0. Address 3 reads 0 and ignores writes.
- R4: Among pending requests, a higher level (`irq_level[2*i+1:2*i]`) always wins over a lower one.
- R5: Within one level, the pending request with the lowest line number wins, unless a fast slot rule applies.
- R6: While valid, `vec_addr` equals {base[13:0], winner[5:0], 1'b0}.
- R7: With no request pending, `vec_valid` is 0 and `vec_fast` is 0.
- R8: A request named by a slot becomes the winner when three conditions hold: it is pending, it is at level 2, and no level-3 request is pending. Its lower line number does not matter. In that case `vec_fast` is 1 and `vec_slot` gives the slot number.
- R9: When both slots name pending level-2 requests, slot 0 wins and `vec_slot` is 0.
- R10: A slot-named request at a level other than 2 is arbitrated as an ordinary request, and `vec_fast` stays 0.
- R11: A pending level-3 request beats any fast-slot request.
- R12: The outputs reflect requests, levels and registers exactly one clock edge after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 64 | Request lines, one per IRQ number |
| irq_level | input | 128 | Packed 2-bit priority level per line |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 base, 1 slot 0, 2 slot 1) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| vec_valid | output | 1 | A request is pending; vector is meaningful |
| vec_addr | output | 21 | Composed vector address |
| vec_fast | output | 1 | Winner is a fast-slot request |
| vec_slot | output | 1 | Which fast slot won |

## Verification
Requests are spread across different levels, to show that level decides the outcome ahead of line number. Several requests are then put on one level, to expose the lowest-number rule. Slot-named lines are placed at level 2 with a lower-numbered ordinary request beside them, which shows the promotion. The same lines are moved to levels 1 and 3 to show that promotion then has no effect. A level-3 request next to a fast candidate, and two slots pointing at pending lines, separate the level-3 override from the slot 0 over slot 1 order. Latency is checked by sampling the outputs just before and just after the edge that follows a change.

// File: rtl/ivg_pkg.sv
// Package: shared sizes and register addresses for the interrupt vector generator.
package ivg_pkg;
    localparam int NUM_IRQ  = 64;
    localparam int IRQ_W    = $clog2(NUM_IRQ);
    localparam int LVL_W    = 2;
    localparam int NUM_LVL  = 1 << LVL_W;
    localparam int BASE_W   = 14;
    localparam int VEC_W    = BASE_W + IRQ_W + 1;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 2;
    localparam logic [LVL_W-1:0] FAST_LVL = LVL_W'(2);

    typedef enum logic [ADDR_W-1:0] {
        RA_BASE  = 2'd0,
        RA_SLOT0 = 2'd1,
        RA_SLOT1 = 2'd2,
        RA_NONE  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/ivg_regs.sv
// Module: ivg_regs
// Holds the vector base and the two fast-slot selectors, with write and read
// decode. Assumes single-cycle writes, and reads that are combinational on the
// address. Unused bits read as zero.
module ivg_regs
    import ivg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [BASE_W-1:0] base_o,
    output logic [IRQ_W-1:0]  slot0_o,
    output logic [IRQ_W-1:0]  slot1_o
);
    // Register write with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o  <= '0;
            slot0_o <= '0;
            slot1_o <= '0;
        end else if (wen) begin
            case (addr)
                RA_BASE:  base_o  <= wdata[BASE_W-1:0];
                RA_SLOT0: slot0_o <= wdata[IRQ_W-1:0];
                RA_SLOT1: slot1_o <= wdata[IRQ_W-1:0];
                default: ;
            endcase
        end
    end

    // Read mux, with zero fill above each field.
    always_comb begin
        rdata = '0;
        case (addr)
            RA_BASE:  rdata[BASE_W-1:0] = base_o;
            RA_SLOT0: rdata[IRQ_W-1:0]  = slot0_o;
            RA_SLOT1: rdata[IRQ_W-1:0]  = slot1_o;
            default:  rdata = '0;
        endcase
    end

    // The base may only change through a write to its address.
    assert_base_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wen && addr == RA_BASE) |=> $stable(base_o));
    // A write to the empty address changes no register.
    assert_empty_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && addr == RA_NONE) |=> ($stable(slot0_o) && $stable(slot1_o)));
endmodule

// File: rtl/ivg_arbiter.sv
// Module: ivg_arbiter
// Combinational arbitration. It finds the highest pending level and the lowest
// line number within that level, then applies the fast-slot override when the
// top pending level is 2. Assumes levels are stable while they are sampled.
module ivg_arbiter
    import ivg_pkg::*;
(
    input  logic [NUM_IRQ-1:0]       req,
    input  logic [NUM_IRQ*LVL_W-1:0] level,
    input  logic [IRQ_W-1:0]         slot0,
    input  logic [IRQ_W-1:0]         slot1,
    output logic                     win_valid,
    output logic [IRQ_W-1:0]         win_idx,
    output logic                     win_fast,
    output logic                     win_slot
);
    logic [NUM_IRQ-1:0] lvl_mask [NUM_LVL];
    logic [LVL_W-1:0]   top_lvl;
    logic [IRQ_W-1:0]   plain_idx;
    logic               hit0, hit1;

    // One pending mask per level, built per request line.
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
            assign lvl_mask[l][i] = req[i] && (level[i*LVL_W +: LVL_W] == LVL_W'(l));
        end
    end

    // Highest level that has any pending line.
    always_comb begin
        top_lvl = '0;
        for (int l = 0; l < NUM_LVL; l++)
            if (|lvl_mask[l]) top_lvl = LVL_W'(l);
    end

    // Lowest pending line number within the top level.
    always_comb begin
        plain_idx = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--)
            if (lvl_mask[top_lvl][i]) plain_idx = IRQ_W'(i);
    end

    // Fast-slot candidates: pending, at the fast level, and that level is on top.
    always_comb begin
        hit0 = req[slot0] && (level[slot0*LVL_W +: LVL_W] == FAST_LVL) && (top_lvl == FAST_LVL);
        hit1 = req[slot1] && (level[slot1*LVL_W +: LVL_W] == FAST_LVL) && (top_lvl == FAST_LVL);
    end

    // Final pick: slot 0, then slot 1, then the plain winner.
    always_comb begin
        win_valid = |req;
        win_fast  = hit0 || hit1;
        win_slot  = !hit0 && hit1;
        if (hit0)      win_idx = slot0;
        else if (hit1) win_idx = slot1;
        else           win_idx = plain_idx;
    end
endmodule

// File: rtl/irq_vector_gen.sv
// Module: irq_vector_gen (top)
// Registers the arbitration result and composes the vector from the base
// register and the winning line number. The outputs follow their inputs with
// a latency of one clock. The reset is synchronous and active low.
module irq_vector_gen
    import ivg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_IRQ-1:0]       irq_req,
    input  logic [NUM_IRQ*LVL_W-1:0] irq_level,
    input  logic                     reg_wen,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    output logic                     vec_valid,
    output logic [VEC_W-1:0]         vec_addr,
    output logic                     vec_fast,
    output logic                     vec_slot
);
    logic [BASE_W-1:0] base;
    logic [IRQ_W-1:0]  slot0, slot1, win_idx;
    logic              win_valid, win_fast, win_slot;

    ivg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .base_o(base),
        .slot0_o(slot0), .slot1_o(slot1)
    );

    ivg_arbiter u_arb (
        .req(irq_req), .level(irq_level), .slot0(slot0), .slot1(slot1),
        .win_valid(win_valid), .win_idx(win_idx),
        .win_fast(win_fast), .win_slot(win_slot)
    );

    // Output register: captures the vector and flags on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_addr  <= '0;
            vec_fast  <= 1'b0;
            vec_slot  <= 1'b0;
        end else begin
            vec_valid <= win_valid;
            vec_addr  <= {base, win_idx, 1'b0};
            vec_fast  <= win_fast;
            vec_slot  <= win_slot;
        end
    end

    // The winner chosen by the arbiter is always a pending line.
    assert_win_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> irq_req[win_idx]);
    // A fast winner sits at the fast level.
    assert_fast_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        win_fast |-> (irq_level[win_idx*LVL_W +: LVL_W] == FAST_LVL));
    // No pending request on one edge gives no valid or fast flag after it.
    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|irq_req) |=> (!vec_valid && !vec_fast));
    // The upper vector bits follow the base held one edge earlier.
    assert_base_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (vec_addr[VEC_W-1 -: BASE_W] == $past(base)));
    // A fast flag only ever appears together with valid.
    assert_fast_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        vec_fast |-> vec_valid);
endmodule

// File: tb/tb_irq_vector_gen.sv
// Directed bench for irq_vector_gen: one task per scenario.
module tb_irq_vector_gen;
    localparam int CLK_PERIOD = 10;
    localparam int N = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [63:0]  irq_req = '0;
    logic [127:0] irq_level = '0;
    logic         reg_wen = 1'b0;
    logic [1:0]   reg_addr = '0;
    logic [15:0]  reg_wdata = '0;
    logic [15:0]  reg_rdata;
    logic         vec_valid, vec_fast, vec_slot;
    logic [20:0]  vec_addr;

    int total = 0;
    int bad = 0;
    logic [13:0] base_m = '0;

    irq_vector_gen dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count one check, and print a line if it fails.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wen = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [15:0] exp);
        @(negedge clk); reg_addr = a; #1;
        chk(req, {16'h0, reg_rdata}, {16'h0, exp});
    endtask

    task automatic set_lvl(input int i, input logic [1:0] l);
        irq_level[i*2 +: 2] = l;
    endtask

    // Apply the stimulus already set, wait one edge, then check the outputs.
    task automatic expect_vec(input string req, input logic v, input logic [5:0] idx,
                              input logic f, input logic s);
        @(negedge clk);
        chk({req, " valid"}, {31'h0, vec_valid}, {31'h0, v});
        if (v) chk({req, " addr"}, {11'h0, vec_addr}, {11'h0, base_m, idx, 1'b0});
        chk({req, " fast"}, {31'h0, vec_fast}, {31'h0, f});
        if (f) chk({req, " slot"}, {31'h0, vec_slot}, {31'h0, s});
    endtask

    task automatic clear_all();
        @(negedge clk); irq_req = '0; irq_level = '0;
    endtask

    task automatic t_reset();
        chk("R1 valid", {31'h0, vec_valid}, 32'h0);
        chk("R1 addr", {11'h0, vec_addr}, 32'h0);
        chk("R1 fast", {30'h0, vec_fast, vec_slot}, 32'h0);
        rd_chk("R1 base", 2'd0, 16'h0);
        rd_chk("R1 slot0", 2'd1, 16'h0);
        rd_chk("R1 slot1", 2'd2, 16'h0);
    endtask

    task automatic t_regs();
        wr(2'd0, 16'hFFFF); rd_chk("R2 base mask", 2'd0, 16'h3FFF);
        wr(2'd0, 16'h2A5B); rd_chk("R2 base value", 2'd0, 16'h2A5B); base_m = 14'h2A5B;
        wr(2'd1, 16'hFFC5); rd_chk("R3 slot0 mask", 2'd1, 16'h0005);
        wr(2'd2, 16'hAB3F); rd_chk("R3 slot1 mask", 2'd2, 16'h003F);
        wr(2'd3, 16'hFFFF); rd_chk("R3 empty addr", 2'd3, 16'h0);
        rd_chk("R3 empty no effect s0", 2'd1, 16'h0005);
        rd_chk("R2 empty no effect base", 2'd0, 16'h2A5B);
    endtask

    task automatic t_idle();
        clear_all();
        expect_vec("R7 idle", 1'b0, 6'd0, 1'b0, 1'b0);
    endtask

    task automatic t_levels();
        clear_all();
        irq_req[3] = 1'b1; set_lvl(3, 2'd1);
        irq_req[40] = 1'b1; set_lvl(40, 2'd3);
        irq_req[10] = 1'b1; set_lvl(10, 2'd2);
        expect_vec("R4 level wins", 1'b1, 6'd40, 1'b0, 1'b0);
        clear_all();
        irq_req[63] = 1'b1; set_lvl(63, 2'd1);
        irq_req[0] = 1'b1; set_lvl(0, 2'd0);
        expect_vec("R4 R6 edge lines", 1'b1, 6'd63, 1'b0, 1'b0);
    endtask

    task automatic t_same_level();
        clear_all();
        irq_req[33] = 1'b1; irq_req[17] = 1'b1; irq_req[50] = 1'b1;
        set_lvl(33, 2'd1); set_lvl(17, 2'd1); set_lvl(50, 2'd1);
        expect_vec("R5 lowest number", 1'b1, 6'd17, 1'b0, 1'b0);
    endtask

    task automatic t_fast();
        // slot0 = 5, slot1 = 63
        clear_all();
        irq_req[2] = 1'b1; set_lvl(2, 2'd2);
        irq_req[63] = 1'b1; set_lvl(63, 2'd2);
        expect_vec("R8 slot1 promoted", 1'b1, 6'd63, 1'b1, 1'b1);
        @(negedge clk); irq_req[5] = 1'b1; set_lvl(5, 2'd2);
        expect_vec("R9 slot0 over slot1", 1'b1, 6'd5, 1'b1, 1'b0);
        @(negedge clk); irq_req[7] = 1'b1; set_lvl(7, 2'd3);
        expect_vec("R11 level3 beats fast", 1'b1, 6'd7, 1'b0, 1'b0);
        clear_all();
        irq_req[2] = 1'b1; set_lvl(2, 2'd1);
        irq_req[5] = 1'b1; set_lvl(5, 2'd1);
        expect_vec("R10 slot at level1 plain", 1'b1, 6'd2, 1'b0, 1'b0);
        clear_all();
        irq_req[5] = 1'b1; set_lvl(5, 2'd3);
        irq_req[1] = 1'b1; set_lvl(1, 2'd3);
        expect_vec("R10 slot at level3 plain", 1'b1, 6'd1, 1'b0, 1'b0);
    endtask

    task automatic t_latency();
        clear_all();
        @(negedge clk);
        irq_req[9] = 1'b1; set_lvl(9, 2'd0);
        @(posedge clk); #0;
        #1;
        chk("R12 updated after one edge", {31'h0, vec_valid}, 32'h1);
        @(negedge clk); irq_req = '0;
        #(CLK_PERIOD/2 - 1);
        chk("R12 held before edge", {31'h0, vec_valid}, 32'h1);
        @(negedge clk);
        chk("R12 cleared after edge", {31'h0, vec_valid}, 32'h0);
        // a base change shows up on the next edge
        irq_req[9] = 1'b1;
        wr(2'd0, 16'h0011); base_m = 14'h0011;
        expect_vec("R12 R6 new base", 1'b1, 6'd9, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_regs();
        t_idle();
        t_levels();
        t_same_level();
        t_fast();
        t_latency();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule